// File: doc/BRIEF.md
# Tunable Quadrature NCO

This block is a numerically controlled oscillator that produces a quadrature pair of sampled sinusoids for a digital phase-locked loop. On every accepted sample it advances a 20-bit phase accumulator, which holds a fraction of one cycle. The step is a base frequency word plus a tuning value that comes from a loop filter. The tuning value is scaled by a fixed gain of 1/4096, done as an arithmetic right shift by 12. Wraparound of the accumulator supplies the modulo-one behaviour.

The cosine and sine presented with each sample are taken from the phase as it stood before that sample's update. This is the one-sample delay that a loop model built from difference equations expects. The top phase bits address a quarter-wave sine table that is computed during elaboration. The lower bits are dropped, so the phase is truncated and not rounded. Both outputs are 12-bit signed values on a scale of 2^11. A valid flag marks the cycle in which each result appears.

Top module: `nco_iq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, phaseOut, cosOut and sinOut are 0 and outValid is 0.
- R2: On a clock edge with sampleValid high, the phase becomes (phase + baseFreq + tuneStep) mod 2^20. phaseOut shows this new phase in the following cycle.
- R3: tuneStep is the signed tuneIn (24 bits, two's complement) shifted right by 12 with sign extension, which is floor(tuneIn/4096). Negative tuning values therefore round toward minus infinity.
- R4: On a clock edge with sampleValid low, phaseOut, cosOut and sinOut keep their values.
- R5: outValid is 1 in the cycle after an edge with sampleValid high, and 0 in the cycle after an edge with sampleValid low.
- R6: The cosOut and sinOut registered on an accepted sample are computed from the phase held before that sample's update.
- R7: With a = phase[19:10] and angle = 2*pi*a/1024, cosOut = round(2048*cos(angle)) and sinOut = round(2048*sin(angle)), rounded half away from zero and clamped to the range -2047..2047. Phase 0 gives cos 2047 and sin 0. Phase 0x40000 gives cos 0 and sin 2047. Phase 0x80000 gives cos -2047 and sin 0.
- R8: The phase wraps modulo 2^20 with no saturation, both for large positive steps and for steps that are negative in net.
- R9: Phase bits 9..0 have no effect on cosOut or sinOut. A phase of 0x003FF gives the same outputs as phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Accept one sample on this edge |
| tuneIn | input | 24 | Signed tuning value from the loop filter |
| baseFreq | input | 20 | Base phase increment per sample |
| cosOut | output | 12 | Signed cosine sample |
| sinOut | output | 12 | Signed sine sample |
| phaseOut | output | 20 | Phase accumulator after the latest accepted sample |
| outValid | output | 1 | Outputs updated in the previous edge |

## Verification
A wrong accumulator value shows up on phaseOut in the cycle after the sample that corrupted it. It reaches cosOut and sinOut one accepted sample later, and only when the error touches the top ten bits. A table or quadrant fault shows only at the phases that address the faulty entry. For that reason the stimulus sweeps the whole circle, using both a slow step and irregular random steps, and it also drives the exact quarter points directly. A fault in the tuning shift becomes visible only when the tuning value is negative and not a multiple of 4096, so such values are driven on purpose.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;   // update the phase accumulator
    logic present;   // load output registers
  } nco_strobe_t;

endpackage

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut #(
  parameter int ADDR_W = 10,
  parameter int OUT_W  = 12
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [OUT_W-1:0]  cosVal,
  output logic signed [OUT_W-1:0]  sinVal
);

  localparam int QN     = 1 << (ADDR_W - 2);
  localparam int MAXV   = (1 << (OUT_W - 1)) - 1;
  localparam real FS    = 2.0 ** (OUT_W - 1);
  localparam real HALFPI = 1.5707963267948966;

  logic [OUT_W-1:0] quarterTab [0:QN];

  // Quarter-wave table, computed at elaboration
  for (genvar k = 0; k <= QN; k++) begin : g_tab
    localparam real ANG = HALFPI * k / QN;
    localparam int  RAW = $rtoi($sin(ANG) * FS + 0.5);
    localparam int  VAL = (RAW > MAXV) ? MAXV : RAW;
    assign quarterTab[k] = VAL[OUT_W-1:0];
  end

  logic signed [OUT_W-1:0] chanVal [2];

  // Channel 0 = sine, channel 1 = cosine (address advanced by a quarter)
  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [ADDR_W-1:0] chAddr;
    logic [1:0]        quad;
    logic [ADDR_W-2:0] idx;
    logic [ADDR_W-2:0] tabIdx;
    logic [OUT_W-1:0]  mag;

    assign chAddr = addr + ADDR_W'(ch * QN);
    assign quad   = chAddr[ADDR_W-1 -: 2];
    assign idx    = {1'b0, chAddr[ADDR_W-3:0]};

    always_comb begin
      tabIdx = quad[0] ? ((ADDR_W-1)'(QN) - idx) : idx;
      mag    = quarterTab[tabIdx];
      chanVal[ch] = quad[1] ? -signed'(mag) : signed'(mag);
    end
  end

  assign sinVal = chanVal[0];
  assign cosVal = chanVal[1];

endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sampleValid,
  output nco_strobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.advance = sampleValid;
    strobe.present = sampleValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= sampleValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> outValid) else $error("valid pulse missing"); // R5
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> !outValid) else $error("spurious valid"); // R5

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int PHASE_W    = 20,
  parameter int TUNE_W     = 24,
  parameter int OUT_W      = 12,
  parameter int LUT_ADDR_W = 10,
  parameter int GAIN_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  nco_strobe_t                strobe,
  input  logic signed [TUNE_W-1:0]   tuneIn,
  input  logic [PHASE_W-1:0]         baseFreq,
  output logic [PHASE_W-1:0]         phaseQ,
  output logic signed [OUT_W-1:0]    cosQ,
  output logic signed [OUT_W-1:0]    sinQ
);

  localparam int EXT_W = (TUNE_W > PHASE_W) ? TUNE_W : PHASE_W;

  logic signed [EXT_W-1:0] tuneWide;
  logic signed [EXT_W-1:0] tuneScaled;
  logic [PHASE_W-1:0]      stepWord;
  logic [PHASE_W-1:0]      phaseNext;
  logic signed [OUT_W-1:0] lutCos;
  logic signed [OUT_W-1:0] lutSin;

  assign tuneWide   = EXT_W'(tuneIn);
  assign tuneScaled = tuneWide >>> GAIN_SHIFT;
  assign stepWord   = baseFreq + tuneScaled[PHASE_W-1:0];
  assign phaseNext  = phaseQ + stepWord;

  nco_sincos_lut #(.ADDR_W(LUT_ADDR_W), .OUT_W(OUT_W)) u_lut (
    .addr   (phaseQ[PHASE_W-1 -: LUT_ADDR_W]),
    .cosVal (lutCos),
    .sinVal (lutSin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseQ <= '0;
    end else if (strobe.advance) begin
      phaseQ <= phaseNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cosQ <= '0;
      sinQ <= '0;
    end else if (strobe.present) begin
      cosQ <= lutCos;
      sinQ <= lutSin;
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance |=> $stable(phaseQ)) else $error("phase moved"); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.present |=> ($stable(cosQ) && $stable(sinQ))) else $error("output moved"); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> phaseQ == PHASE_W'($past(phaseQ) + $past(baseFreq) + $past(tuneScaled[PHASE_W-1:0])))
    else $error("phase step wrong"); // R2
  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cosQ != -(1 <<< (OUT_W-1))) && (sinQ != -(1 <<< (OUT_W-1)))) else $error("unclamped code"); // R7

endmodule

// File: rtl/nco_iq_top.sv
module nco_iq_top
  import nco_pkg::*;
#(
  parameter int PHASE_W    = 20,
  parameter int TUNE_W     = 24,
  parameter int OUT_W      = 12,
  parameter int LUT_ADDR_W = 10,
  parameter int GAIN_SHIFT = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sampleValid,
  input  logic signed [TUNE_W-1:0]  tuneIn,
  input  logic [PHASE_W-1:0]        baseFreq,
  output logic signed [OUT_W-1:0]   cosOut,
  output logic signed [OUT_W-1:0]   sinOut,
  output logic [PHASE_W-1:0]        phaseOut,
  output logic                      outValid
);

  nco_strobe_t strobe;

  nco_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleValid (sampleValid),
    .strobe      (strobe),
    .outValid    (outValid)
  );

  nco_datapath #(
    .PHASE_W    (PHASE_W),
    .TUNE_W     (TUNE_W),
    .OUT_W      (OUT_W),
    .LUT_ADDR_W (LUT_ADDR_W),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .tuneIn   (tuneIn),
    .baseFreq (baseFreq),
    .phaseQ   (phaseOut),
    .cosQ     (cosOut),
    .sinQ     (sinOut)
  );

endmodule

// File: tb/tb_nco_iq_top.sv
module tb_nco_iq_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [23:0] tuneIn = '0;
  logic [19:0] baseFreq = '0;
  logic signed [11:0] cosOut, sinOut;
  logic [19:0] phaseOut;
  logic outValid;

  int checkCount = 0;
  int failCount  = 0;

  longint mPhase = 0;
  int mCos = 0, mSin = 0, mValid = 0;

  always #4 clk = ~clk;

  nco_iq_top dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .tuneIn(tuneIn),
    .baseFreq(baseFreq), .cosOut(cosOut), .sinOut(sinOut),
    .phaseOut(phaseOut), .outValid(outValid)
  );

  function automatic int refWave(longint ph, bit isCos);
    real ang, v;
    int r;
    ang = 2.0 * 3.141592653589793 * real'(ph / 1024) / 1024.0;
    v = (isCos ? $cos(ang) : $sin(ang)) * 2048.0;
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    if (r > 2047) r = 2047;
    if (r < -2047) r = -2047;
    return r;
  endfunction

  function automatic longint floorDiv4096(longint t);
    longint m;
    m = ((t % 4096) + 4096) % 4096;
    return (t - m) / 4096;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    check(int'(phaseOut) == mPhase, {tag, " phase"}, phaseOut, mPhase);
    check(int'(cosOut) == mCos, {tag, " cos"}, cosOut, mCos);
    check(int'(sinOut) == mSin, {tag, " sin"}, sinOut, mSin);
    check(int'(outValid) == mValid, {tag, " valid"}, outValid, mValid);
  endtask

  // Compare previous result, then drive one sample and advance the model
  task automatic step(bit v, int t, int b, string tag);
    @(negedge clk);
    compareAll(tag);
    sampleValid = v;
    tuneIn = t[23:0];
    baseFreq = b[19:0];
    if (v) begin
      mCos = refWave(mPhase, 1'b1);
      mSin = refWave(mPhase, 1'b0);
      mPhase = (((mPhase + b + floorDiv4096(t)) % 1048576) + 1048576) % 1048576;
      mValid = 1;
    end else begin
      mValid = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mPhase = 0; mCos = 0; mSin = 0; mValid = 0;
  endtask

  initial begin
    #(8 * 200000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 0, 0, "R1 reset");

    // R7: quarter points with base a quarter cycle
    for (int i = 0; i < 6; i++) step(1'b1, 0, 20'h40000, "R7 quarter");

    // R9: low phase bits ignored
    doReset();
    step(1'b1, 0, 20'h003FF, "R9 low bits");
    step(1'b1, 0, 0, "R9 low bits");
    step(1'b0, 0, 0, "R9 low bits");
    check(cosOut == 12'sd2047 && sinOut == 12'sd0, "R9 direct", cosOut, 2047);

    // R2 R6 R7: slow sweep over whole circle
    doReset();
    for (int i = 0; i < 1100; i++) step(1'b1, 0, 1024, "R2 R6 sweep");

    // R3: negative tuning, not multiples of 4096
    for (int i = 0; i < 200; i++) step(1'b1, -4095 - 37 * i, 3000, "R3 negtune");

    // R4 R5: gaps in sampleValid
    for (int i = 0; i < 300; i++)
      step(1'($urandom_range(0, 2) == 0), int'($urandom_range(0, 65535)) - 32768,
           int'($urandom_range(0, 4095)), "R4 R5 gaps");

    // R8: wraparound, large positive and net-negative steps
    for (int i = 0; i < 300; i++) step(1'b1, 0, 20'hF0001, "R8 wrap pos");
    for (int i = 0; i < 300; i++) step(1'b1, -8388608, 100, "R8 wrap neg");

    // Random mix
    for (int i = 0; i < 2000; i++)
      step(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 16777215)) - 8388608,
           int'($urandom_range(0, 1048575)), "R2 R3 R6 random");

    step(1'b0, 0, 0, "R4 final");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule